// File: doc/BRIEF.md
# Interrupt CPU-Target Register File

This block holds one 8-bit CPU-target mask per interrupt line of an interrupt distributor. Bit c of a mask means "CPU c may receive this interrupt". Software reaches the masks through a simple register bus that carries either a single byte or a whole 32-bit word. Because every interrupt owns exactly one byte, the byte offset on the bus is the interrupt ID. A word access spans four neighbouring IDs.

The first 32 IDs are private to each CPU, and their targets are fixed. Writes to them are dropped. A read of them returns, in every byte, the bit of the CPU making the access. The shared IDs follow, and their number is a parameter. Every byte written to a shared ID is first clipped to the CPUs that are currently online. IDs past the shared range read as zero and drop writes.

Alongside each stored mask the block keeps one chosen delivery CPU: the lowest set bit of the mask, or CPU 0 when the mask is empty. A combinational lookup port returns that choice for any interrupt ID, for use by delivery logic.

Top module: `tgt_route_regs`

## Requirements
- R1: After reset every shared mask is zero, so reads of shared IDs return zero and the lookup of any shared ID returns CPU 0.
- R2: A byte access (busWide = 0) addresses interrupt ID busAddr. Write data is taken from busWdata[7:0], and read data appears in busRdata[7:0] with busRdata[31:8] zero.
- R3: A word access (busWide = 1) ignores busAddr[1:0] and covers IDs base to base+3. The ID base+i sits in bits [8i+7:8i], so the lowest ID is in the low byte.
- R4: Writes to IDs 0 to 31 are ignored, whether they are byte or word writes.
- R5: A read of an ID from 0 to 31 returns, in that byte, the value 1 << busCpu.
- R6: A byte written to a shared ID is stored ANDed with an online mask of ones in bits [N-1:0], where N = onlineCount. N = 0 gives an empty mask, and N above 8 counts as 8.
- R7: lookupCpu for a shared ID is the index of the lowest set bit of that ID's stored mask. It is 0 when the mask is zero.
- R8: IDs at or above 32 + NUM_SHARED read as zero and ignore writes. lookupCpu is 0 for any ID that is not shared, including IDs 0 to 31.
- R9: Read data and rdValid appear one cycle after a read request, and rdValid stays low after a write. A byte write changes only the addressed ID, and a later write replaces both the mask and the chosen CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWide | input | 1 | 1 = 32-bit word access, 0 = byte access |
| busAddr | input | ADDR_W | Byte offset, equal to the interrupt ID |
| busWdata | input | 32 | Write data, one byte per interrupt |
| busCpu | input | 3 | Index of the CPU making the access |
| onlineCount | input | CNT_W | Number of CPUs online |
| busRdata | output | 32 | Registered read data |
| rdValid | output | 1 | busRdata is valid this cycle |
| lookupId | input | ADDR_W | Interrupt ID to resolve |
| lookupCpu | output | 3 | Chosen delivery CPU for lookupId |

## Verification
Target masks are written with several kinds of value: a single bit, several bits, full ones, and an empty byte. Each kind is read back and also resolved through the lookup port. This separates a wrong lowest-bit choice from a missing fallback to CPU 0 on an empty mask.

Word writes and reads use distinct values in each lane, including a word address with nonzero low bits. This exposes lane swaps and alignment errors. The online count is swept through 0, 3, 5 and a value above 8, which shows whether clipping is applied and whether it saturates.

Private-range, last-shared and first-beyond-range IDs are hit with both reads and writes. Shared neighbours are read back afterwards, so that any write leaking across a range boundary or into an adjacent byte shows up.

// File: rtl/tgt_pkg.sv
`timescale 1ns/1ps
package tgt_pkg;
  localparam int TGT_W    = 8;
  localparam int CPU_W    = 3;
  localparam int LANES    = 4;
  localparam int PRIV_IDS = 32;
  localparam int BUS_W    = TGT_W * LANES;

  typedef struct packed {
    logic [LANES-1:0] laneWr;
    logic [LANES-1:0] laneShr;
    logic [LANES-1:0] lanePriv;
    logic             rdStb;
    logic             isByte;
  } tgtStrb_t;
endpackage

// File: rtl/tgt_lowbit.sv
`timescale 1ns/1ps
module tgt_lowbit #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  maskIn,
  output logic [IW-1:0] idxOut
);
  always_comb begin
    idxOut = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (maskIn[i]) idxOut = IW'(i);
    end
  end
endmodule

// File: rtl/tgt_ctrl.sv
`timescale 1ns/1ps
module tgt_ctrl
  import tgt_pkg::*;
#(
  parameter int NUM_SHARED = 64,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 4
) (
  input  logic                           busValid,
  input  logic                           busWrite,
  input  logic                           busWide,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [CNT_W-1:0]               onlineCount,
  output tgtStrb_t                       strb,
  output logic [$clog2(NUM_SHARED)-1:0]  sharedBase,
  output logic [TGT_W-1:0]               onMask
);
  localparam int TOTAL  = PRIV_IDS + NUM_SHARED;
  localparam int SIDX_W = $clog2(NUM_SHARED);
  localparam int IDW    = ADDR_W + 1;

  logic [IDW-1:0]   baseId;
  logic [IDW-1:0]   laneId [LANES];
  logic [LANES-1:0] laneOn, lanePrivV, laneShrV;

  // word accesses drop the two low address bits
  assign baseId = busWide ? {1'b0, busAddr[ADDR_W-1:2], 2'b00} : {1'b0, busAddr};
  assign sharedBase = SIDX_W'(baseId - IDW'(PRIV_IDS));

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneId[l]    = baseId + IDW'(l);
      laneOn[l]    = busWide || (l == 0);
      lanePrivV[l] = laneOn[l] && (laneId[l] < IDW'(PRIV_IDS));
      laneShrV[l]  = laneOn[l] && (laneId[l] >= IDW'(PRIV_IDS)) && (laneId[l] < IDW'(TOTAL));
    end
  end

  always_comb begin
    strb.laneWr   = (busValid && busWrite) ? laneShrV : '0;
    strb.laneShr  = laneShrV;
    strb.lanePriv = lanePrivV;
    strb.rdStb    = busValid && !busWrite;
    strb.isByte   = !busWide;
  end

  // online mask: ones in bits below the online count, saturating
  always_comb begin
    for (int c = 0; c < TGT_W; c++) begin
      onMask[c] = (int'(onlineCount) > c);
    end
  end
endmodule

// File: rtl/tgt_dpath.sv
`timescale 1ns/1ps
module tgt_dpath
  import tgt_pkg::*;
#(
  parameter int NUM_SHARED = 64,
  parameter int ADDR_W     = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  tgtStrb_t                       strb,
  input  logic [$clog2(NUM_SHARED)-1:0]  sharedBase,
  input  logic [TGT_W-1:0]               onMask,
  input  logic [BUS_W-1:0]               busWdata,
  input  logic [CPU_W-1:0]               busCpu,
  input  logic [ADDR_W-1:0]              lookupId,
  output logic [BUS_W-1:0]               busRdata,
  output logic                           rdValid,
  output logic [CPU_W-1:0]               lookupCpu
);
  localparam int TOTAL  = PRIV_IDS + NUM_SHARED;
  localparam int SIDX_W = $clog2(NUM_SHARED);

  logic [TGT_W-1:0]  maskMem [NUM_SHARED];
  logic [CPU_W-1:0]  pickMem [NUM_SHARED];
  logic [SIDX_W-1:0] laneIdx [LANES];
  logic [TGT_W-1:0]  clipped [LANES];
  logic [CPU_W-1:0]  pickL   [LANES];
  logic [BUS_W-1:0]  rdNext;
  logic              lookupHit;
  logic [SIDX_W-1:0] lkIdx;

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    assign laneIdx[L] = sharedBase + SIDX_W'(L);
    assign clipped[L] = busWdata[L*TGT_W +: TGT_W] & onMask;
    tgt_lowbit #(.W(TGT_W), .IW(CPU_W)) u_pick (
      .maskIn(clipped[L]),
      .idxOut(pickL[L])
    );
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (strb.laneShr[l])
        rdNext[l*TGT_W +: TGT_W] = maskMem[laneIdx[l]];
      else if (strb.lanePriv[l])
        rdNext[l*TGT_W +: TGT_W] = TGT_W'(1) << busCpu;
      else
        rdNext[l*TGT_W +: TGT_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SHARED; s++) begin
        maskMem[s] <= '0;
        pickMem[s] <= '0;
      end
      busRdata <= '0;
      rdValid  <= 1'b0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strb.laneWr[l]) begin
          maskMem[laneIdx[l]] <= clipped[l];
          pickMem[laneIdx[l]] <= pickL[l];
        end
      end
      rdValid <= strb.rdStb;
      if (strb.rdStb) busRdata <= rdNext;
    end
  end

  assign lookupHit = (lookupId >= ADDR_W'(PRIV_IDS)) && (lookupId < ADDR_W'(TOTAL));
  assign lkIdx     = SIDX_W'(lookupId - ADDR_W'(PRIV_IDS));
  assign lookupCpu = lookupHit ? pickMem[lkIdx] : '0;

  // R6: a stored byte never holds a CPU that was offline when it was written
  a_r6_clip_online: assert property (@(posedge clk) disable iff (!rstN)
    strb.laneWr[0] |=> ((maskMem[$past(laneIdx[0])] & ~$past(onMask)) == '0))
    else $error("a_r6_clip_online");

  // R7: the kept pick is a set bit of the mask with no lower set bit
  a_r7_lowest_bit: assert property (@(posedge clk) disable iff (!rstN)
    (lookupHit && (maskMem[lkIdx] != '0)) |->
      (maskMem[lkIdx][lookupCpu] &&
       ((maskMem[lkIdx] & ((TGT_W'(1) << lookupCpu) - TGT_W'(1))) == '0)))
    else $error("a_r7_lowest_bit");

  // R7: an empty mask resolves to CPU 0
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (lookupHit && (maskMem[lkIdx] == '0)) |-> (lookupCpu == '0))
    else $error("a_r7_empty_zero");

  // R8: IDs outside the shared range resolve to CPU 0
  a_r8_nonshared_lookup: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (lookupCpu == '0))
    else $error("a_r8_nonshared_lookup");

  // R2: byte reads leave the upper three bytes clear
  a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(strb.isByte)) |-> (busRdata[BUS_W-1:TGT_W] == '0))
    else $error("a_r2_byte_upper_zero");
endmodule

// File: rtl/tgt_route_regs.sv
`timescale 1ns/1ps
module tgt_route_regs
  import tgt_pkg::*;
#(
  parameter int NUM_SHARED = 64,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               busWide,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  input  logic [2:0]         busCpu,
  input  logic [CNT_W-1:0]   onlineCount,
  output logic [31:0]        busRdata,
  output logic               rdValid,
  input  logic [ADDR_W-1:0]  lookupId,
  output logic [2:0]         lookupCpu
);
  localparam int SIDX_W = $clog2(NUM_SHARED);

  tgtStrb_t          strb;
  logic [SIDX_W-1:0] sharedBase;
  logic [TGT_W-1:0]  onMask;

  tgt_ctrl #(.NUM_SHARED(NUM_SHARED), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busWide(busWide),
    .busAddr(busAddr), .onlineCount(onlineCount),
    .strb(strb), .sharedBase(sharedBase), .onMask(onMask)
  );

  tgt_dpath #(.NUM_SHARED(NUM_SHARED), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sharedBase(sharedBase),
    .onMask(onMask), .busWdata(busWdata), .busCpu(busCpu),
    .lookupId(lookupId), .busRdata(busRdata), .rdValid(rdValid),
    .lookupCpu(lookupCpu)
  );
endmodule

// File: tb/sim_tgt_route_regs.sv
`timescale 1ns/1ps
module sim_tgt_route_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, busWide = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [2:0]  busCpu = '0;
  logic [3:0]  onlineCount = 4'd8;
  logic [31:0] busRdata;
  logic        rdValid;
  logic [9:0]  lookupId = '0;
  logic [2:0]  lookupCpu;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tgt_route_regs #(.NUM_SHARED(64), .ADDR_W(10), .CNT_W(4)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWide(busWide), .busAddr(busAddr), .busWdata(busWdata),
    .busCpu(busCpu), .onlineCount(onlineCount), .busRdata(busRdata),
    .rdValid(rdValid), .lookupId(lookupId), .lookupCpu(lookupCpu)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int addr, input bit wide, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busWide = wide;
    busAddr = 10'(addr); busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    chk("R9 rdValid low after write", 32'(rdValid), 32'd0);
  endtask

  task automatic rd(input int addr, input bit wide, input logic [2:0] cpu,
                    output logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busWide = wide;
    busAddr = 10'(addr); busCpu = cpu;
    @(negedge clk);
    data = busRdata;
    chk("R9 rdValid one cycle after read", 32'(rdValid), 32'd1);
    busValid = 1'b0;
  endtask

  task automatic look(input int id, output logic [2:0] cpu);
    lookupId = 10'(id);
    #1;
    cpu = lookupCpu;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [2:0] c;
    chk("R1 rdValid idle after reset", 32'(rdValid), 32'd0);
    rd(40, 1'b0, 3'd0, d); chk("R1 shared byte zero", d, 32'h0);
    rd(64, 1'b1, 3'd0, d); chk("R1 shared word zero", d, 32'h0);
    look(50, c); chk("R1 lookup zero", 32'(c), 32'd0);
  endtask

  task automatic t_byte();
    logic [31:0] d; logic [2:0] c;
    onlineCount = 4'd8;
    wr(33, 1'b0, 32'hFFFF_FF24);
    rd(33, 1'b0, 3'd0, d); chk("R2 byte readback", d, 32'h0000_0024);
    look(33, c); chk("R7 lowest bit of 0x24", 32'(c), 32'd2);
    rd(32, 1'b0, 3'd0, d); chk("R9 neighbour below untouched", d, 32'h0);
    rd(34, 1'b0, 3'd0, d); chk("R9 neighbour above untouched", d, 32'h0);
  endtask

  task automatic t_wide();
    logic [31:0] d; logic [2:0] c;
    wr(42, 1'b1, 32'h8010_0300);
    rd(40, 1'b1, 3'd0, d); chk("R3 word lanes", d, 32'h8010_0300);
    rd(43, 1'b1, 3'd0, d); chk("R3 low addr bits ignored", d, 32'h8010_0300);
    rd(42, 1'b0, 3'd0, d); chk("R3 lane 2 as byte", d, 32'h0000_0010);
    look(40, c); chk("R7 empty mask picks 0", 32'(c), 32'd0);
    look(41, c); chk("R7 lowest of 0x03", 32'(c), 32'd0);
    look(42, c); chk("R7 lowest of 0x10", 32'(c), 32'd4);
    look(43, c); chk("R7 lowest of 0x80", 32'(c), 32'd7);
    wr(42, 1'b0, 32'h0000_0006);
    look(42, c); chk("R9 overwrite repicks", 32'(c), 32'd1);
    rd(43, 1'b0, 3'd0, d); chk("R9 overwrite keeps neighbour", d, 32'h0000_0080);
  endtask

  task automatic t_priv();
    logic [31:0] d; logic [2:0] c;
    wr(0, 1'b1, 32'hFFFF_FFFF);
    wr(31, 1'b0, 32'h0000_00FF);
    wr(30, 1'b1, 32'hFFFF_FFFF);
    rd(0, 1'b1, 3'd3, d); chk("R5 private word cpu3", d, 32'h0808_0808);
    rd(31, 1'b0, 3'd5, d); chk("R5 private byte cpu5", d, 32'h0000_0020);
    rd(28, 1'b1, 3'd0, d); chk("R4 private word stays fixed", d, 32'h0101_0101);
    rd(32, 1'b0, 3'd0, d); chk("R4 no spill into first shared", d, 32'h0);
    look(31, c); chk("R8 lookup of private id", 32'(c), 32'd0);
  endtask

  task automatic t_clip();
    logic [31:0] d; logic [2:0] c;
    onlineCount = 4'd3;
    wr(60, 1'b0, 32'h0000_00F8);
    rd(60, 1'b0, 3'd0, d); chk("R6 all offline bits dropped", d, 32'h0);
    look(60, c); chk("R6 clipped empty picks 0", 32'(c), 32'd0);
    wr(61, 1'b0, 32'h0000_00FC);
    rd(61, 1'b0, 3'd0, d); chk("R6 clip to 3 cpus", d, 32'h0000_0004);
    look(61, c); chk("R6 pick after clip", 32'(c), 32'd2);
    onlineCount = 4'd0;
    wr(62, 1'b0, 32'h0000_00FF);
    rd(62, 1'b0, 3'd0, d); chk("R6 zero online", d, 32'h0);
    onlineCount = 4'd12;
    wr(63, 1'b0, 32'h0000_00FF);
    rd(63, 1'b0, 3'd0, d); chk("R6 count saturates at 8", d, 32'h0000_00FF);
    onlineCount = 4'd5;
    wr(64, 1'b1, 32'h6030_1FE0);
    rd(64, 1'b1, 3'd0, d); chk("R6 word clip to 5 cpus", d, 32'h0010_1F00);
    onlineCount = 4'd8;
  endtask

  task automatic t_range();
    logic [31:0] d; logic [2:0] c;
    wr(95, 1'b0, 32'h0000_0040);
    rd(95, 1'b0, 3'd0, d); chk("R8 last shared id kept", d, 32'h0000_0040);
    look(95, c); chk("R8 last shared id pick", 32'(c), 32'd6);
    wr(96, 1'b0, 32'h0000_00FF);
    rd(96, 1'b0, 3'd0, d); chk("R8 beyond range reads zero", d, 32'h0);
    wr(100, 1'b1, 32'hFFFF_FFFF);
    rd(100, 1'b1, 3'd0, d); chk("R8 beyond range word zero", d, 32'h0);
    look(96, c); chk("R8 lookup beyond range", 32'(c), 32'd0);
    rd(92, 1'b1, 3'd0, d); chk("R8 last shared word intact", d, 32'h4000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_byte();
    t_wide();
    t_priv();
    t_clip();
    t_range();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule